// File: doc/BRIEF.md
# Ping-Pong ROM Signature Tester

This block is a built-in self-test engine for a control ROM built as two physical halves. While it is idle, the ROM is addressed from the functional address input. A start command switches it to test mode. In test mode a command register inside the block drives the ROM address. The register walks every address exhaustively. Each address is followed at once by its bitwise complement, so every address line toggles between consecutive words.

Each half feeds its own 16-bit serial signature register. The register divides the bit stream of that half by the CCITT polynomial x^16 + x^12 + x^5 + 1, taking one data bit per clock. The quotient bit of either half can be watched on a single test pin while compression runs. After the last word, both final signatures are shifted out on the same pin. A done flag is then raised and held. The external tester compares the streams against golden values.

Both ROM halves are modelled inside the block by closed-form contents. Their address and data are brought out as ports for observation.

Top module: `ping_pong_rom_bist`

## Requirements
- R1: After reset, `done` and `test_out` are 0 and `rom_addr` equals `func_addr`.
- R2: Outside the compress and readout phases, `rom_addr` follows `func_addr`. For an address a zero-extended to 16 bits, half 0 returns (a*0x2F1B mod 2^16) XOR 0xA5C3 and half 1 returns (a*0x6D4F mod 2^16) XOR 0x3C96, shown on `rom0_data` and `rom1_data` in the same cycle.
- R3: Test addresses are applied in the order 0, ~0, 1, ~1, ..., max, ~max, where ~ is the ADDR_W-bit complement. Each address is held for 16 clocks, and the first one appears in the cycle after `start` is sampled.
- R4: Sampling `start` seeds both signature registers with 0xFFFF. Each compress clock folds one data bit of the half's current word, MSB first. The quotient q is the register MSB XOR the data bit. The next register value is the register shifted left by one, XOR 0x1021 when q is 1.
- R5: During compress, `test_out` shows the quotient of half 0 when `out_sel` is 0 and the quotient of half 1 when `out_sel` is 1.
- R6: For the 32 clocks after the last compress clock, `test_out` carries signature 0 MSB first and then signature 1 MSB first, when `out_sel[1]` is 1.
- R7: `test_out` is 0 whenever the selected stream is not active: in idle and done, during readout with `out_sel[1]` = 0, and during compress with `out_sel[1]` = 1.
- R8: A `start` asserted during compress or readout is ignored. Timing, quotients and signatures are unchanged.
- R9: `done` rises in the cycle after the last readout bit and stays 1 until the next `start`. A new `start` clears it and runs a complete fresh test with re-seeded signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a self-test (sampled when idle or done) |
| out_sel | input | 2 | Test pin source: 0 quotient half 0, 1 quotient half 1, 2/3 signature readout |
| func_addr | input | ADDR_W | Functional ROM address used outside test |
| rom_addr | output | ADDR_W | Address applied to both ROM halves |
| rom0_data | output | 16 | Word read from ROM half 0 |
| rom1_data | output | 16 | Word read from ROM half 1 |
| test_out | output | 1 | Serial test pin |
| done | output | 1 | Test complete, held until next start |

## Verification
The full test is run with three pin selections: quotient of half 0, quotient of half 1, and signature readout. Each bit on the pin is compared with a bench model of the division. Comparing the two quotient runs separates the two halves' ROM contents and feedback paths. In those same runs the pin must stay low during readout. In the readout run it must stay low during compress, which tells a stream leaking onto the wrong phase apart from a correct one. A run with a stray start pulse mid-compress, followed by a back-to-back restart from done, tells a correct re-seed from a corrupted or restarted sequence. A table of functional addresses checks address pass-through and ROM contents outside test, including the all-zero and all-one corners.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int NUM_HALVES = 2;
    localparam int SIG_W      = 16;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;

    localparam logic [15:0] ROM_MUL [NUM_HALVES] = '{16'h2F1B, 16'h6D4F};
    localparam logic [15:0] ROM_XOR [NUM_HALVES] = '{16'hA5C3, 16'h3C96};

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COMPRESS = 2'd1,
        ST_READOUT  = 2'd2,
        ST_DONE     = 2'd3
    } bist_state_e;

endpackage

// File: rtl/rom_half.sv
module rom_half #(
    parameter int          ADDR_W = 4,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MUL    = 16'h0001,
    parameter logic [15:0] XMASK  = 16'h0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] ext;
    logic [DATA_W-1:0] prod;

    always_comb begin
        ext  = DATA_W'(addr);
        prod = ext * DATA_W'(MUL);
        data = prod ^ DATA_W'(XMASK);
    end
endmodule

// File: rtl/addr_seq.sv
module addr_seq #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] test_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic              last
);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              phase;
        logic [BIT_W-1:0]  bidx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (clear) begin
            seq_d.cnt   = '0;
            seq_d.phase = 1'b0;
            seq_d.bidx  = BIT_W'(DATA_W - 1);
        end else if (step) begin
            if (seq_q.bidx == '0) begin
                seq_d.bidx = BIT_W'(DATA_W - 1);
                if (seq_q.phase) begin
                    seq_d.phase = 1'b0;
                    seq_d.cnt   = seq_q.cnt + 1'b1;
                end else begin
                    seq_d.phase = 1'b1;
                end
            end else begin
                seq_d.bidx = seq_q.bidx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{cnt: '0, phase: 1'b0, bidx: BIT_W'(DATA_W - 1)};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign test_addr = seq_q.phase ? ~seq_q.cnt : seq_q.cnt;
    assign bit_idx   = seq_q.bidx;
    assign last      = (seq_q.cnt == '1) && seq_q.phase && (seq_q.bidx == '0);

    // R3: a finished true word is followed by its complement
    p_pingpong_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !seq_q.phase && seq_q.bidx == '0)
        |=> (test_addr == ~$past(test_addr)));

    // R3: a finished complement word advances the counter by one
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && seq_q.phase && seq_q.bidx == '0 && !last)
        |=> (seq_q.cnt == $past(seq_q.cnt) + 1'b1) && !seq_q.phase);

    // R3: each word is held while its bits are consumed
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && seq_q.bidx != '0) |=> $stable(test_addr));
endmodule

// File: rtl/sig_reg.sv
module sig_reg #(
    parameter int             SIG_W = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic step,
    input  logic shift,
    input  logic din,
    input  logic shin,
    output logic quot,
    output logic msb
);
    typedef struct packed {
        logic [SIG_W-1:0] sig;
    } sr_t;

    sr_t sr_d, sr_q;

    assign quot = sr_q.sig[SIG_W-1] ^ din;
    assign msb  = sr_q.sig[SIG_W-1];

    always_comb begin
        sr_d = sr_q;
        if (seed) begin
            sr_d.sig = '1;
        end else if (step) begin
            sr_d.sig = {sr_q.sig[SIG_W-2:0], 1'b0} ^ (quot ? POLY : '0);
        end else if (shift) begin
            sr_d.sig = {sr_q.sig[SIG_W-2:0], shin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '{sig: '1};
        end else begin
            sr_q <= sr_d;
        end
    end

    // R4: a start seeds the register with all ones
    p_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (sr_q.sig == '1));

    // R9: with no command the signature is retained
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed && !step && !shift) |=> $stable(sr_q.sig));
endmodule

// File: rtl/ping_pong_rom_bist.sv
module ping_pong_rom_bist #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        out_sel,
    input  logic [ADDR_W-1:0] func_addr,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [15:0]       rom0_data,
    output logic [15:0]       rom1_data,
    output logic              test_out,
    output logic              done
);
    import bist_pkg::*;

    localparam int BIT_W  = $clog2(DATA_W);
    localparam int RD_LEN = NUM_HALVES * SIG_W;
    localparam int RD_W   = $clog2(RD_LEN);

    typedef struct packed {
        bist_state_e     st;
        logic [RD_W-1:0] rd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              seq_clear, seq_step, sig_shift, seq_last;
    logic [ADDR_W-1:0] test_addr;
    logic [BIT_W-1:0]  bit_idx;
    logic              active;

    logic [DATA_W-1:0] word  [NUM_HALVES];
    logic              quot  [NUM_HALVES];
    logic              smsb  [NUM_HALVES];

    // control sequencing
    always_comb begin
        ctl_d     = ctl_q;
        seq_clear = 1'b0;
        seq_step  = 1'b0;
        sig_shift = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ctl_d.st  = ST_COMPRESS;
                    ctl_d.rd  = '0;
                    seq_clear = 1'b1;
                end
            end
            ST_COMPRESS: begin
                seq_step = 1'b1;
                if (seq_last) begin
                    ctl_d.st = ST_READOUT;
                    ctl_d.rd = '0;
                end
            end
            ST_READOUT: begin
                sig_shift = 1'b1;
                ctl_d.rd  = ctl_q.rd + 1'b1;
                if (ctl_q.rd == RD_W'(RD_LEN - 1)) begin
                    ctl_d.st = ST_DONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, rd: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // command register: test address source
    addr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_clear),
        .step      (seq_step),
        .test_addr (test_addr),
        .bit_idx   (bit_idx),
        .last      (seq_last)
    );

    assign active   = (ctl_q.st == ST_COMPRESS);
    assign rom_addr = active ? test_addr : func_addr;

    // one ROM half and one signature register per physical section
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        logic shin;

        rom_half #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .MUL    (ROM_MUL[g]),
            .XMASK  (ROM_XOR[g])
        ) u_rom (
            .addr (rom_addr),
            .data (word[g])
        );

        if (g == NUM_HALVES - 1) begin : g_tail
            assign shin = 1'b0;
        end else begin : g_chain
            assign shin = smsb[g+1];
        end

        sig_reg #(.SIG_W(SIG_W), .POLY(SIG_POLY)) u_sig (
            .clk   (clk),
            .rst_n (rst_n),
            .seed  (seq_clear),
            .step  (seq_step),
            .shift (sig_shift),
            .din   (word[g][bit_idx]),
            .shin  (shin),
            .quot  (quot[g]),
            .msb   (smsb[g])
        );
    end

    assign rom0_data = 16'(word[0]);
    assign rom1_data = 16'(word[1]);

    // test pin source selection
    always_comb begin
        test_out = 1'b0;
        if (out_sel[1]) begin
            test_out = (ctl_q.st == ST_READOUT) && smsb[0];
        end else if (active) begin
            test_out = out_sel[0] ? quot[1] : quot[0];
        end
    end

    assign done = (ctl_q.st == ST_DONE);

    // R9: done holds until a new start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a start from done clears the flag
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R7: pin is quiet while no test stream is running
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE || ctl_q.st == ST_DONE) |-> !test_out);

    // R8: compress continues regardless of start
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_COMPRESS && !seq_last) |=> (ctl_q.st == ST_COMPRESS));

    // R6: readout runs its full length
    p_rd_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_READOUT && ctl_q.rd != RD_W'(RD_LEN - 1))
        |=> (ctl_q.st == ST_READOUT));

    // R2: outside test the ROM sees the functional address
    p_func_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_COMPRESS) |-> (rom_addr == func_addr));
endmodule

// File: tb/test_ping_pong_rom_bist.sv
`timescale 1ns/1ps
module test_ping_pong_rom_bist;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NW = 2 * (1 << AW);
    localparam int L  = NW * DW;

    localparam logic [15:0] MUL [2] = '{16'h2F1B, 16'h6D4F};
    localparam logic [15:0] XOR [2] = '{16'hA5C3, 16'h3C96};
    localparam logic [AW-1:0] VEC_ADDR [6] = '{4'h0, 4'h5, 4'hA, 4'hF, 4'h3, 4'hC};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    out_sel;
    logic [AW-1:0] func_addr;
    logic [AW-1:0] rom_addr;
    logic [15:0]   rom0_data, rom1_data;
    logic          test_out, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ping_pong_rom_bist #(.ADDR_W(AW), .DATA_W(DW)) i_ping_pong_rom_bist (
        .clk(clk), .rst_n(rst_n), .start(start), .out_sel(out_sel),
        .func_addr(func_addr), .rom_addr(rom_addr), .rom0_data(rom0_data),
        .rom1_data(rom1_data), .test_out(test_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mword(input int h, input logic [AW-1:0] a);
        logic [15:0] p;
        p = 16'(a) * MUL[h];
        return p ^ XOR[h];
    endfunction

    function automatic logic [15:0] sstep(input logic [15:0] s, input logic q);
        return {s[14:0], 1'b0} ^ (q ? 16'h1021 : 16'h0000);
    endfunction

    // one full self-test; inject pulses start in the middle of compress
    task automatic run_test(input logic [1:0] sel, input bit inject, input bit from_done);
        logic [15:0] s0, s1;
        logic [31:0] rdbits;
        int bad_a, bad_d, bad_q, bad_dn, bad_rd;
        bad_a = 0; bad_d = 0; bad_q = 0; bad_dn = 0; bad_rd = 0;
        @(negedge clk);
        out_sel = sel;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        if (from_done) chk(done === 1'b0, "R9 done cleared by restart", 32'(done), 32'h0);
        s0 = 16'hFFFF;
        s1 = 16'hFFFF;
        for (int k = 0; k < L; k++) begin
            int w, b;
            logic [AW-1:0] a, ea;
            logic [15:0] d0, d1;
            logic q0, q1, eo;
            w  = k / DW;
            b  = DW - 1 - (k % DW);
            a  = AW'(w / 2);
            ea = (w % 2 == 1) ? ~a : a;
            d0 = mword(0, ea);
            d1 = mword(1, ea);
            if (rom_addr !== ea) bad_a++;
            if (rom0_data !== d0 || rom1_data !== d1) bad_d++;
            q0 = s0[15] ^ d0[b];
            q1 = s1[15] ^ d1[b];
            eo = (sel == 2'd0) ? q0 : (sel == 2'd1) ? q1 : 1'b0;
            if (test_out !== eo) bad_q++;
            if (done !== 1'b0) bad_dn++;
            if (inject && k == 100) start = 1'b1;
            if (inject && k == 101) start = 1'b0;
            s0 = sstep(s0, q0);
            s1 = sstep(s1, q1);
            @(negedge clk);
        end
        rdbits = {s0, s1};
        for (int j = 0; j < 32; j++) begin
            logic eo;
            eo = sel[1] ? rdbits[31-j] : 1'b0;
            if (test_out !== eo) bad_rd++;
            if (done !== 1'b0) bad_dn++;
            if (inject && j == 5) start = 1'b1;
            if (inject && j == 6) start = 1'b0;
            @(negedge clk);
        end
        chk(bad_a == 0, "R3 ping-pong address order", 32'(bad_a), 32'h0);
        chk(bad_d == 0, "R2 ROM contents during test", 32'(bad_d), 32'h0);
        if (sel[1]) begin
            chk(bad_q == 0, "R7 pin quiet in compress with readout select", 32'(bad_q), 32'h0);
            chk(bad_rd == 0, "R6 R4 signature readout stream", 32'(bad_rd), 32'h0);
        end else begin
            chk(bad_q == 0, "R5 R4 quotient stream", 32'(bad_q), 32'h0);
            chk(bad_rd == 0, "R7 pin quiet in readout with quotient select", 32'(bad_rd), 32'h0);
        end
        if (inject) chk(bad_q == 0 && bad_rd == 0, "R8 stray start ignored", 32'(bad_q + bad_rd), 32'h0);
        chk(bad_dn == 0, "R9 done low while running", 32'(bad_dn), 32'h0);
        chk(done === 1'b1, "R9 done after last readout bit", 32'(done), 32'h1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        out_sel   = 2'd0;
        func_addr = 4'h6;
        @(negedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R1 done after reset", 32'(done), 32'h0);
        chk(test_out === 1'b0, "R1 test_out after reset", 32'(test_out), 32'h0);
        chk(rom_addr === 4'h6, "R1 rom_addr after reset", 32'(rom_addr), 32'h6);
        rst_n = 1'b1;

        // vector table: functional address pass-through and ROM contents
        for (int i = 0; i < 6; i++) begin
            func_addr = VEC_ADDR[i];
            @(negedge clk);
            chk(rom_addr === VEC_ADDR[i], "R2 functional address", 32'(rom_addr), 32'(VEC_ADDR[i]));
            chk(rom0_data === mword(0, VEC_ADDR[i]), "R2 half 0 word", 32'(rom0_data), 32'(mword(0, VEC_ADDR[i])));
            chk(rom1_data === mword(1, VEC_ADDR[i]), "R2 half 1 word", 32'(rom1_data), 32'(mword(1, VEC_ADDR[i])));
            chk(test_out === 1'b0, "R7 pin quiet in idle", 32'(test_out), 32'h0);
        end

        run_test(2'd0, 1'b0, 1'b0);
        run_test(2'd1, 1'b0, 1'b1);
        run_test(2'd2, 1'b1, 1'b1);

        // done held, pin quiet, functional address restored
        func_addr = 4'h9;
        out_sel   = 2'd3;
        repeat (8) @(negedge clk);
        chk(done === 1'b1, "R9 done held", 32'(done), 32'h1);
        chk(test_out === 1'b0, "R7 pin quiet in done", 32'(test_out), 32'h0);
        chk(rom_addr === 4'h9, "R2 functional address in done", 32'(rom_addr), 32'h9);

        // back-to-back restart must reproduce the same signatures
        run_test(2'd3, 1'b0, 1'b1);

        finish_up();
    end
endmodule